// File: doc/BRIEF.md
# Controller-to-Matrix Key Mapper

This block lets a gamepad drive the scanned key matrix of a handheld-game processor. Each game carries its own configuration table: one 7-bit action code for every position of an 8-row by 4-column matrix. A position either names a controller action or holds the unused marker 0x7f. The processor strobes one row at a time. The mapper answers on a 4-bit K nibble with the state of the keys wired to that row. It also raises a wake line whenever any mapped key in any row is held, which lets a halted processor resume before it has selected a row.

Two start actions exist. When the loaded table never names the second-start action, the Start button also produces the first-start action, so games with a single start key work from either Select or Start. Two shared-line actions cover games that tie several inputs to one matrix position. One follows either vertical direction. The other follows Button1.

Top module: `keymap_matrix_top`

## Requirements
- R1: Reset is synchronous and active-low. On the first clock edge with `rst_n` low, `k_out` and `wake_out` become 0, and they stay 0 while reset is held.
- R2: The row selector is the 0-based index of the strobe line. One clock edge after the inputs are applied, `k_out[j]` equals the pressed state of table entry `row_sel*4 + j`. Entry n occupies `cfg_table[n*7 +: 7]`, and K is active-high.
- R3: An entry holding 0x7f drives neither a K bit nor the wake line.
- R4: Codes 12 to 126 are undefined and act exactly like 0x7f.
- R5: One edge after the inputs are applied, `wake_out` is the OR over all 32 entries of their pressed state, regardless of `row_sel`.
- R6: If no entry holds code 9 (second start), code 8 (first start) is pressed when Select (bit 8) or Start (bit 9) is held.
- R7: If some entry holds code 9, code 8 follows Select alone and code 9 follows Start alone.
- R8: Code 10, the shared vertical line, is pressed when Up (bit 0) or Down (bit 1) is held.
- R9: Code 11, the shared button/hour line, is pressed when Button1 (bit 4) is held.
- R10: Codes 0 to 7 follow button bits 0 to 7: Up, Down, Left, Right, Button1, Button2, Button3 and Button4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_in | input | 10 | Controller buttons, 1 = held. Bits 0..7 as in R10, bit 8 Select, bit 9 Start |
| cfg_table | input | 224 | 32 entries of 7-bit action codes, row-major, 4 entries per row |
| row_sel | input | 3 | 0-based index of the strobed row |
| k_out | output | 4 | Registered K nibble for the selected row |
| wake_out | output | 1 | Registered OR of all pressed mapped keys |

## Verification
The row-gated K nibble and the ungated wake line are produced in the same cycle from the same entries, and they must disagree whenever the only pressed key sits on an unselected row. The bench provokes this directly by pressing a key mapped outside `row_sel`. Random tables and selectors provoke it as well. It expects K to be zero and wake to be set. The start fallback can also flip in the same cycle a key lookup happens: adding a single code-9 entry changes what Start produces on other rows. Directed pairs of tables, with and without that entry, judge both results against the bench model.

// File: rtl/keymap_pkg.sv
// Shared constants for the key mapper: code width, action codes and
// controller button bit positions. Assumes action codes fit in 4 bits.
package keymap_pkg;
    localparam int ACT_W     = 7;
    localparam int NUM_ACT   = 12;
    localparam int ACT_IDX_W = $clog2(NUM_ACT);
    localparam int NUM_BTN   = 10;

    localparam logic [ACT_W-1:0] CODE_UNUSED = 7'h7f;

    // action codes (index into the action vector)
    localparam int A_UP     = 0;
    localparam int A_DOWN   = 1;
    localparam int A_LEFT   = 2;
    localparam int A_RIGHT  = 3;
    localparam int A_B1     = 4;
    localparam int A_B2     = 5;
    localparam int A_B3     = 6;
    localparam int A_B4     = 7;
    localparam int A_START1 = 8;
    localparam int A_START2 = 9;
    localparam int A_UPDOWN = 10;
    localparam int A_HOUR   = 11;

    // controller button bits
    localparam int B_SELECT = 8;
    localparam int B_START  = 9;
endpackage

// File: rtl/keymap_action_decode.sv
// Turns the raw button vector into one pressed flag per action code.
// Applies the start fallback and the shared-line actions.
// Assumes btn bits 0..7 line up with action codes 0..7.
module keymap_action_decode
    import keymap_pkg::*;
(
    input  logic [NUM_BTN-1:0] btn,
    input  logic               start2_mapped,
    output logic [NUM_ACT-1:0] act
);
    // one flag per action; direct codes first, then the special lines
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            act[i] = btn[i];
        end
        act[A_START1] = btn[B_SELECT] | (btn[B_START] & ~start2_mapped);
        act[A_START2] = btn[B_START] & start2_mapped;
        act[A_UPDOWN] = btn[A_UP] | btn[A_DOWN];
        act[A_HOUR]   = btn[A_B1];
    end
endmodule

// File: rtl/keymap_cell.sv
// One matrix position. It looks up its action code in the action vector.
// Any code outside the defined set, the unused marker included, gives 0.
// It also flags whether it names the second-start action.
module keymap_cell
    import keymap_pkg::*;
(
    input  logic [ACT_W-1:0]   code,
    input  logic [NUM_ACT-1:0] act,
    output logic               hit,
    output logic               names_start2
);
    // pressed state of this position
    always_comb begin
        hit = 1'b0;
        if (code < ACT_W'(NUM_ACT)) begin
            hit = act[code[ACT_IDX_W-1:0]];
        end
    end

    // second-start detection from the code alone
    assign names_start2 = (code == ACT_W'(A_START2));

    // undefined codes and the marker stay silent (R3, R4)
    always_comb begin
        p_unused_silent_r3: assert (!((code == CODE_UNUSED) && hit));
        p_undefined_silent_r4: assert (!((code >= ACT_W'(NUM_ACT)) && hit));
    end
endmodule

// File: rtl/keymap_row_select.sv
// Picks the K nibble of the strobed row and ORs every position into a
// row-independent wake flag. Assumes entries are stored row-major.
module keymap_row_select #(
    parameter int ROWS  = 8,
    parameter int KBITS = 4
) (
    input  logic [ROWS*KBITS-1:0]    hits,
    input  logic [$clog2(ROWS)-1:0]  row_sel,
    output logic [KBITS-1:0]         k_row,
    output logic                     any_hit
);
    // K nibble of the selected row
    always_comb begin
        for (int j = 0; j < KBITS; j++) begin
            k_row[j] = hits[int'(row_sel) * KBITS + j];
        end
    end

    // ungated wake
    assign any_hit = |hits;
endmodule

// File: rtl/keymap_matrix_top.sv
// Controller-to-matrix key mapper. It decodes buttons into actions,
// resolves each matrix position against the per-game table, and registers
// the selected row's K nibble and the wake flag.
// Assumes the table is static while read. Reset is synchronous, active-low.
module keymap_matrix_top
    import keymap_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int KBITS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BTN-1:0]            btn_in,
    input  logic [ROWS*KBITS*ACT_W-1:0]   cfg_table,
    input  logic [$clog2(ROWS)-1:0]       row_sel,
    output logic [KBITS-1:0]              k_out,
    output logic                          wake_out
);
    localparam int ENTRIES = ROWS * KBITS;

    logic [NUM_ACT-1:0] act;
    logic [ENTRIES-1:0] hits;
    logic [ENTRIES-1:0] start2_flags;
    logic               start2_mapped;
    logic [KBITS-1:0]   k_row;
    logic               any_hit;

    // second start present anywhere in the table
    assign start2_mapped = |start2_flags;

    keymap_action_decode u_decode (
        .btn           (btn_in),
        .start2_mapped (start2_mapped),
        .act           (act)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
        keymap_cell u_cell (
            .code         (cfg_table[e*ACT_W +: ACT_W]),
            .act          (act),
            .hit          (hits[e]),
            .names_start2 (start2_flags[e])
        );
    end

    keymap_row_select #(.ROWS(ROWS), .KBITS(KBITS)) u_rows (
        .hits    (hits),
        .row_sel (row_sel),
        .k_row   (k_row),
        .any_hit (any_hit)
    );

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_out    <= '0;
            wake_out <= 1'b0;
        end else begin
            k_out    <= k_row;
            wake_out <= any_hit;
        end
    end

    // reset clears both outputs on the next edge (R1)
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (k_out == '0 && !wake_out));

    // a key seen on the selected row must also be seen by wake (R5)
    p_k_implies_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (k_out != '0) |-> wake_out);

    // with nothing held, the next cycle shows no wake (R5)
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_in == '0) |=> !wake_out);

    // with nothing held, the next K nibble is empty (R2)
    p_idle_k_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_in == '0) |=> (k_out == '0));
endmodule

// File: tb/tb_keymap_matrix_top.sv
module tb_keymap_matrix_top;
    localparam int ROWS = 8;
    localparam int KB   = 4;
    localparam int AW   = 7;
    localparam int NE   = ROWS * KB;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [9:0]           btn_in = '0;
    logic [NE*AW-1:0]     cfg_table = '1;
    logic [2:0]           row_sel = '0;
    logic [3:0]           k_out;
    logic                 wake_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    keymap_matrix_top dut (
        .clk(clk), .rst_n(rst_n), .btn_in(btn_in), .cfg_table(cfg_table),
        .row_sel(row_sel), .k_out(k_out), .wake_out(wake_out)
    );

    function automatic bit has_s2(input logic [NE*AW-1:0] t);
        for (int e = 0; e < NE; e++) if (t[e*AW +: AW] == 7'd9) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit pressed(input int code, input logic [9:0] b, input bit s2);
        case (code)
            0, 1, 2, 3, 4, 5, 6, 7: return b[code];
            8:  return b[8] | (b[9] & !s2);
            9:  return b[9] & s2;
            10: return b[0] | b[1];
            11: return b[4];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] exp_k(input logic [NE*AW-1:0] t, input logic [9:0] b, input int r);
        logic [3:0] k;
        bit s2 = has_s2(t);
        for (int j = 0; j < KB; j++) k[j] = pressed(int'(t[(r*KB+j)*AW +: AW]), b, s2);
        return k;
    endfunction

    function automatic bit exp_w(input logic [NE*AW-1:0] t, input logic [9:0] b);
        bit s2 = has_s2(t);
        for (int e = 0; e < NE; e++) if (pressed(int'(t[e*AW +: AW]), b, s2)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic set_entry(input int row, input int col, input int code);
        cfg_table[(row*KB+col)*AW +: AW] = AW'(code);
    endtask

    task automatic check_k(input string req, input logic [3:0] exp);
        checks++;
        if (k_out !== exp) begin
            errors++;
            $display("FAIL %s k_out actual=%b expected=%b", req, k_out, exp);
        end
    endtask

    task automatic check_w(input string req, input bit exp);
        checks++;
        if (wake_out !== exp) begin
            errors++;
            $display("FAIL %s wake_out actual=%b expected=%b", req, wake_out, exp);
        end
    endtask

    // drive at negedge, let one edge register, sample at the next negedge
    task automatic apply(input logic [9:0] b, input int r);
        @(negedge clk);
        btn_in  = b;
        row_sel = 3'(r);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic auto_check(input string rk, input string rw);
        check_k(rk, exp_k(cfg_table, btn_in, int'(row_sel)));
        check_w(rw, exp_w(cfg_table, btn_in));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: reset with keys held
        cfg_table = '1;
        set_entry(0, 0, 0);
        btn_in = 10'h3ff;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_k("R1", 4'b0000);
        check_w("R1", 1'b0);
        rst_n = 1'b1;

        // R3: every entry unused, all buttons held
        cfg_table = '1;
        apply(10'h3ff, 3);
        check_k("R3", 4'b0000);
        check_w("R3", 1'b0);

        // R4: undefined codes
        for (int e = 0; e < NE; e++) cfg_table[e*AW +: AW] = AW'(12 + e * 3);
        apply(10'h3ff, 5);
        check_k("R4", 4'b0000);
        check_w("R4", 1'b0);

        // R6: single start table, Start drives first start
        cfg_table = '1;
        set_entry(2, 1, 8);
        apply(10'h200, 2);
        check_k("R6", 4'b0010);
        check_w("R6", 1'b1);
        apply(10'h100, 2);
        check_k("R6", 4'b0010);

        // R7: second start present, split behaviour
        set_entry(5, 0, 9);
        apply(10'h200, 2);
        check_k("R7", 4'b0000);
        apply(10'h200, 5);
        check_k("R7", 4'b0001);
        apply(10'h100, 2);
        check_k("R7", 4'b0010);
        apply(10'h100, 5);
        check_k("R7", 4'b0000);

        // R8: shared vertical line
        cfg_table = '1;
        set_entry(0, 3, 10);
        apply(10'h002, 0);
        check_k("R8", 4'b1000);
        apply(10'h001, 0);
        check_k("R8", 4'b1000);
        apply(10'h00c, 0);
        check_k("R8", 4'b0000);

        // R9: shared button/hour line
        cfg_table = '1;
        set_entry(7, 2, 11);
        apply(10'h010, 7);
        check_k("R9", 4'b0100);
        apply(10'h020, 7);
        check_k("R9", 4'b0000);

        // R5: key on an unselected row wakes but shows no K
        cfg_table = '1;
        set_entry(1, 0, 0);
        apply(10'h001, 6);
        check_k("R5", 4'b0000);
        check_w("R5", 1'b1);

        // R10: direct action codes
        for (int c = 0; c < 8; c++) begin
            cfg_table = '1;
            set_entry(c, c % 4, c);
            apply(10'(1 << c), c);
            check_k("R10", 4'(1 << (c % 4)));
        end

        // R2 / R5: random tables, buttons and rows
        for (int it = 0; it < 400; it++) begin
            for (int e = 0; e < NE; e++) begin
                int r = int'($urandom % 16);
                if (r < 12) cfg_table[e*AW +: AW] = AW'(r);
                else if (r == 14) cfg_table[e*AW +: AW] = AW'(12 + ($urandom % 100));
                else cfg_table[e*AW +: AW] = 7'h7f;
            end
            apply(10'($urandom), int'($urandom % 8));
            auto_check("R2", "R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule